// File: doc/BRIEF.md
# Shared Program and Scratchpad Memory

This block is one dual-port memory holding both the instruction store of a small 8-bit soft processor and its data scratchpad. Port A reads the store at word granularity and returns an 18-bit instruction one clock after the address is presented. Port B reads and writes single bytes. Its byte address is formed by prefixing the 8-bit effective address with three 1 bits, so the 256-byte scratchpad occupies the top 128 instruction words. There is no separate data RAM.

The effective address is the sum of one of 16 general registers, chosen by a select input, and a constant offset taken from the instruction. The sum is computed in the same cycle as the access. Fetch, store, input and output all share this adder, and the block drives the sum on `ea_o` for the I/O path. Nothing is written back to the register file, so the base register keeps its value.

A word-wide load port fills program memory for test purposes. The storage itself is not reset.

Top module: `smem_shared_mem`

## Requirements
- R1: `instr_o` shows the 18-bit word at the `instr_addr_i` value sampled at a rising clock edge, starting from that edge.
- R2: When `load_en_i` is high, a rising edge writes all 18 bits of `load_data_i` to word `load_addr_i`.
- R3: `ea_o` equals (register[`base_sel_i`] + `off_i`) mod 256 in the same cycle. Register n occupies bits [8n+7:8n] of `regs_i`, and any of the 16 registers can be the base.
- R4: The scratchpad byte address is {3'b111, `ea_o`}. Byte ea therefore lies in word 896 + ea/2.
- R5: An even ea addresses bits [7:0] of its word and an odd ea addresses bits [15:8]. `sp_rdata_o` shows that byte one edge after the address is sampled.
- R6: A store (`sp_we_i`) writes `sp_wdata_i` to one byte only. The other byte and bits [17:16] of the word keep their values.
- R7: Stores to ea 0xFE and 0xFF modify word 1023, the interrupt vector, and the change is visible on port A.
- R8: When a store and a read of the same word share an edge, port A and port B both return the word as it was before the store.
- R9: When `load_en_i` and `sp_we_i` are both high, only the load is performed and the store is dropped.
- R10: While reset is asserted and after it is released, `instr_o` and `sp_rdata_o` read zero until the first read edge.
- R11: Because the register-plus-offset sum wraps, a store never modifies any word below 896.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_addr_i | input | 10 | Instruction word address |
| instr_o | output | 18 | Registered instruction word |
| load_en_i | input | 1 | Program load write enable |
| load_addr_i | input | 10 | Program load word address |
| load_data_i | input | 18 | Program load word |
| regs_i | input | 128 | All 16 general registers, register n at bits [8n+7:8n] |
| base_sel_i | input | 4 | Base register number |
| off_i | input | 8 | Constant offset from the instruction |
| sp_we_i | input | 1 | Scratchpad byte store enable |
| sp_wdata_i | input | 8 | Scratchpad store byte |
| ea_o | output | 8 | Effective address, shared with the I/O path |
| sp_rdata_o | output | 8 | Registered scratchpad fetch byte |

## Verification
A fault in the byte-lane mask or in the address prefix corrupts a word that is not the target. The bench reads back neighbouring bytes and the top 2 bits through port A, so such a corruption shows one cycle after the store. A write-priority fault leaves the dropped store in memory, where a later port A read finds it. A read-path ordering fault returns the new data on the colliding edge instead of the old data, and shows immediately on both read ports.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_LOAD = 2'd1,
    WR_BYTE = 2'd2
  } smem_wr_src_e;
endpackage

// File: rtl/smem_ea_gen.sv
module smem_ea_gen #(
  parameter int REG_N = 16,
  parameter int DW    = 8,
  parameter int SEL_W = $clog2(REG_N)
) (
  input  logic [REG_N*DW-1:0] regs_i,
  input  logic [SEL_W-1:0]    base_sel_i,
  input  logic [DW-1:0]       off_i,
  output logic [DW-1:0]       ea_o
);
  logic [DW-1:0] reg_arr [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_unpack
    assign reg_arr[g] = regs_i[g*DW +: DW];
  end

  // modulo 2^DW wrap keeps the access inside the scratchpad
  assign ea_o = reg_arr[base_sel_i] + off_i;
endmodule

// File: rtl/smem_wr_mux.sv
module smem_wr_mux
  import smem_pkg::*;
#(
  parameter int WORD_AW = 10,
  parameter int WORD_W  = 18,
  parameter int DW      = 8
) (
  input  logic               load_en_i,
  input  logic [WORD_AW-1:0] load_addr_i,
  input  logic [WORD_W-1:0]  load_data_i,
  input  logic               sp_we_i,
  input  logic [DW-1:0]      ea_i,
  input  logic [DW-1:0]      sp_wdata_i,
  output logic [WORD_AW-1:0] sp_word_addr_o,
  output smem_wr_src_e       wr_src_o,
  output logic [WORD_AW-1:0] wr_addr_o,
  output logic [WORD_W-1:0]  wr_mask_o,
  output logic [WORD_W-1:0]  wr_data_o
);
  localparam int HI_W = WORD_AW - (DW - 1);

  logic [WORD_W-1:0] lane_mask;
  logic [WORD_W-1:0] lane_data;

  assign sp_word_addr_o = {{HI_W{1'b1}}, ea_i[DW-1:1]};

  always_comb begin
    lane_mask = WORD_W'({DW{1'b1}});
    lane_data = WORD_W'(sp_wdata_i);
    if (ea_i[0]) begin
      lane_mask = lane_mask << DW;
      lane_data = lane_data << DW;
    end
  end

  always_comb begin
    wr_src_o  = WR_IDLE;
    wr_addr_o = load_addr_i;
    wr_mask_o = '1;
    wr_data_o = load_data_i;
    if (load_en_i) begin
      wr_src_o = WR_LOAD;
    end else if (sp_we_i) begin
      wr_src_o  = WR_BYTE;
      wr_addr_o = sp_word_addr_o;
      wr_mask_o = lane_mask;
      wr_data_o = lane_data;
    end
  end
endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int AW = 10,
  parameter int W  = 18,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wmask_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= (mem[waddr_i] & ~wmask_i) | (wdata_i & wmask_i);
  end

  // read-before-write on both ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_a_o <= '0;
      rdata_b_o <= '0;
    end else begin
      rdata_a_o <= mem[raddr_a_i];
      rdata_b_o <= mem[raddr_b_i];
    end
  end
endmodule

// File: rtl/smem_shared_mem.sv
module smem_shared_mem
  import smem_pkg::*;
#(
  parameter int WORD_AW = 10,
  parameter int WORD_W  = 18,
  parameter int DW      = 8,
  parameter int REG_N   = 16,
  localparam int SEL_W  = $clog2(REG_N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_AW-1:0]  instr_addr_i,
  output logic [WORD_W-1:0]   instr_o,
  input  logic                load_en_i,
  input  logic [WORD_AW-1:0]  load_addr_i,
  input  logic [WORD_W-1:0]   load_data_i,
  input  logic [REG_N*DW-1:0] regs_i,
  input  logic [SEL_W-1:0]    base_sel_i,
  input  logic [DW-1:0]       off_i,
  input  logic                sp_we_i,
  input  logic [DW-1:0]       sp_wdata_i,
  output logic [DW-1:0]       ea_o,
  output logic [DW-1:0]       sp_rdata_o
);
  logic [WORD_AW-1:0] sp_word_addr;
  smem_wr_src_e       wr_src;
  logic [WORD_AW-1:0] wr_addr;
  logic [WORD_W-1:0]  wr_mask;
  logic [WORD_W-1:0]  wr_data;
  logic [WORD_W-1:0]  rdata_b;
  logic               hi_sel_q;

  smem_ea_gen #(.REG_N(REG_N), .DW(DW), .SEL_W(SEL_W)) u_ea (
    .regs_i     (regs_i),
    .base_sel_i (base_sel_i),
    .off_i      (off_i),
    .ea_o       (ea_o)
  );

  smem_wr_mux #(.WORD_AW(WORD_AW), .WORD_W(WORD_W), .DW(DW)) u_wr_mux (
    .load_en_i      (load_en_i),
    .load_addr_i    (load_addr_i),
    .load_data_i    (load_data_i),
    .sp_we_i        (sp_we_i),
    .ea_i           (ea_o),
    .sp_wdata_i     (sp_wdata_i),
    .sp_word_addr_o (sp_word_addr),
    .wr_src_o       (wr_src),
    .wr_addr_o      (wr_addr),
    .wr_mask_o      (wr_mask),
    .wr_data_o      (wr_data)
  );

  smem_array #(.AW(WORD_AW), .W(WORD_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_src != WR_IDLE),
    .waddr_i   (wr_addr),
    .wmask_i   (wr_mask),
    .wdata_i   (wr_data),
    .raddr_a_i (instr_addr_i),
    .rdata_a_o (instr_o),
    .raddr_b_i (sp_word_addr),
    .rdata_b_o (rdata_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_sel_q <= 1'b0;
    else         hi_sel_q <= ea_o[0];
  end

  assign sp_rdata_o = DW'(rdata_b >> (hi_sel_q ? DW : 0));
endmodule

// File: rtl/smem_shared_mem_chk.sv
module smem_shared_mem_chk
  import smem_pkg::*;
#(
  parameter int WORD_AW = 10,
  parameter int WORD_W  = 18,
  parameter int DW      = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_en_i,
  input logic [WORD_AW-1:0] load_addr_i,
  input logic               sp_we_i,
  input logic [DW-1:0]      ea_o,
  input smem_wr_src_e       wr_src,
  input logic [WORD_AW-1:0] wr_addr,
  input logic [WORD_W-1:0]  wr_mask
);
  localparam int HI_W = WORD_AW - (DW - 1);
  localparam int TOP_W = WORD_W - 2 * DW;

  a_r9_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_i |-> (wr_src == WR_LOAD) && (wr_addr == load_addr_i) && (&wr_mask));

  a_r4_top_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_i && !load_en_i) |-> (wr_src == WR_BYTE) && (&wr_addr[WORD_AW-1 -: HI_W])
      && (wr_addr[WORD_AW-HI_W-1:0] == ea_o[DW-1:1]));

  a_r6_one_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_i && !load_en_i) |-> ($countones(wr_mask) == DW) && (wr_mask[WORD_W-1 -: TOP_W] == '0));

  a_r5_lane_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_i && !load_en_i) |-> (ea_o[0] ? (&wr_mask[2*DW-1:DW]) : (&wr_mask[DW-1:0])));

  a_r2_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sp_we_i && !load_en_i) |-> (wr_src == WR_IDLE));
endmodule

bind smem_shared_mem smem_shared_mem_chk #(
  .WORD_AW(WORD_AW), .WORD_W(WORD_W), .DW(DW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_en_i   (load_en_i),
  .load_addr_i (load_addr_i),
  .sp_we_i     (sp_we_i),
  .ea_o        (ea_o),
  .wr_src      (wr_src),
  .wr_addr     (wr_addr),
  .wr_mask     (wr_mask)
);

// File: tb/smem_shared_mem_tb.sv
module smem_shared_mem_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [9:0]   instr_addr_i = '0;
  logic [17:0]  instr_o;
  logic         load_en_i = 1'b0;
  logic [9:0]   load_addr_i = '0;
  logic [17:0]  load_data_i = '0;
  logic [127:0] regs_i;
  logic [3:0]   base_sel_i = '0;
  logic [7:0]   off_i = '0;
  logic         sp_we_i = 1'b0;
  logic [7:0]   sp_wdata_i = '0;
  logic [7:0]   ea_o;
  logic [7:0]   sp_rdata_o;

  logic [7:0]  regs [16];
  logic [17:0] exp_mem [1024];
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  always_comb
    for (int i = 0; i < 16; i++) regs_i[i*8 +: 8] = regs[i];

  smem_shared_mem u_dut (.*);

  function automatic logic [17:0] pat(int a);
    return 18'(a * 1237 + 'h2A5C3);
  endfunction

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic rd_word(int a, string req);
    instr_addr_i = 10'(a);
    cyc();
    chk(req, instr_o, exp_mem[a]);
  endtask

  task automatic store(int sel, logic [7:0] base, logic [7:0] off, logic [7:0] d);
    logic [7:0] ea;
    int w;
    regs[sel] = base; base_sel_i = 4'(sel); off_i = off;
    sp_wdata_i = d; sp_we_i = 1'b1;
    ea = base + off;
    w = 896 + int'(ea[7:1]);
    cyc();
    sp_we_i = 1'b0;
    if (ea[0]) exp_mem[w][15:8] = d; else exp_mem[w][7:0] = d;
  endtask

  task automatic t_reset();
    #1;
    chk("R10 instr in reset", instr_o, '0);
    chk("R10 byte in reset", 18'(sp_rdata_o), '0);
    @(negedge clk_i); rst_ni = 1'b1;
    chk("R10 instr after reset", instr_o, '0);
    chk("R10 byte after reset", 18'(sp_rdata_o), '0);
  endtask

  task automatic t_fill();
    load_en_i = 1'b1;
    for (int a = 0; a < 1024; a++) begin
      load_addr_i = 10'(a); load_data_i = pat(a); exp_mem[a] = pat(a);
      cyc();
    end
    load_en_i = 1'b0;
    rd_word(0, "R2 word 0");
    rd_word(517, "R1 word 517");
    rd_word(1023, "R1 word 1023");
    rd_word(895, "R2 word 895");
  endtask

  task automatic t_ea();
    off_i = 8'h37;
    for (int s = 0; s < 16; s++) begin
      regs[s] = 8'(s * 19 + 200);
      base_sel_i = 4'(s);
      #1;
      chk("R3 ea per base", 18'(ea_o), 18'(8'(regs[s] + 8'h37)));
    end
  endtask

  task automatic t_store();
    store(2, 8'h10, 8'h04, 8'hA5);   // ea 0x14 -> word 906 low
    rd_word(906, "R4 R6 even store");
    store(3, 8'h10, 8'h05, 8'h3C);   // ea 0x15 -> word 906 high
    rd_word(906, "R5 R6 odd store keeps low and top");
    regs[4] = 8'h14; base_sel_i = 4'd4; off_i = 8'h01;
    cyc();
    chk("R5 odd fetch", 18'(sp_rdata_o), 18'h3C);
    off_i = 8'h00;
    cyc();
    chk("R5 even fetch", 18'(sp_rdata_o), 18'hA5);
    store(7, 8'h00, 8'h00, 8'h5A);   // ea 0 -> word 896
    rd_word(896, "R4 first scratch word");
  endtask

  task automatic t_vector();
    store(15, 8'hFF, 8'h00, 8'hC3);
    rd_word(1023, "R7 vector high byte");
    store(15, 8'hFF, 8'hFF, 8'h96);  // ea 0xFE
    rd_word(1023, "R7 vector low byte");
  endtask

  task automatic t_rbw();
    logic [17:0] old;
    old = exp_mem[1023];
    instr_addr_i = 10'd1023;
    regs[1] = 8'hFE; base_sel_i = 4'd1; off_i = 8'h00;
    sp_wdata_i = 8'h11; sp_we_i = 1'b1;
    cyc();
    sp_we_i = 1'b0;
    exp_mem[1023][7:0] = 8'h11;
    chk("R8 port A old word", instr_o, old);
    chk("R8 port B old byte", 18'(sp_rdata_o), 18'(old[7:0]));
    cyc();
    chk("R8 port A new word", instr_o, exp_mem[1023]);
    chk("R8 port B new byte", 18'(sp_rdata_o), 18'h11);
  endtask

  task automatic t_priority();
    regs[6] = 8'h20; base_sel_i = 4'd6; off_i = 8'h00;  // word 912
    load_en_i = 1'b1; load_addr_i = 10'd1000; load_data_i = 18'h2BEEF;
    sp_we_i = 1'b1; sp_wdata_i = 8'h77;
    cyc();
    load_en_i = 1'b0; sp_we_i = 1'b0;
    exp_mem[1000] = 18'h2BEEF;
    rd_word(1000, "R9 load done");
    rd_word(912, "R9 store dropped");
    regs[6] = 8'hFE;
    load_en_i = 1'b1; load_addr_i = 10'd1023; load_data_i = 18'h1ABCD;
    sp_we_i = 1'b1; sp_wdata_i = 8'h00;
    cyc();
    load_en_i = 1'b0; sp_we_i = 1'b0;
    exp_mem[1023] = 18'h1ABCD;
    rd_word(1023, "R9 same word load wins");
  endtask

  task automatic t_wrap();
    store(5, 8'hF0, 8'h20, 8'hE1);   // wraps to 0x10 -> word 904
    rd_word(904, "R11 wrapped store");
    rd_word(895, "R11 below scratch untouched");
    rd_word(0, "R11 low program untouched");
    rd_word(392, "R11 alias word untouched");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    t_reset();
    t_fill();
    t_ea();
    t_store();
    t_vector();
    t_rbw();
    t_priority();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule